// File: doc/BRIEF.md
# Low-Power Encoder and Edge Counter

This block is a small counting peripheral behind a simple word-wide register port. In counter mode it counts up, either on every clock or on a selectable edge of phase input A. In encoder mode it counts up or down from two quadrature phases, A and B. The direction of each step comes from which edge is active and the level the other phase holds at that moment.

Software configures the mode and edge selection, then sets the enable bit. While the block is enabled it programs the ceiling and compare values, and each accepted write raises its own confirmation flag. Software then sets the start bit to begin continuous counting. The count wraps to zero above the ceiling and wraps back to the ceiling below zero. Both phase inputs must already be synchronised to the block clock.

Register map (word address on `bus_addr`):

| Address | Name | Contents |
|---|---|---|
| 0 | control | bit0 enable, bit1 start |
| 1 | configuration | bit0 encoder select, bit1 external-source select, bits[3:2] edge select |
| 2 | ceiling | ceiling value |
| 3 | compare | compare value |
| 4 | count | current count, read-only |
| 5 | status | bit0 ceiling-OK, bit1 compare-OK |
| 6 | clear | write 1 to clear the matching status bit |

Edge select codes: 00 rising, 01 falling, 10 or 11 both edges.

Top module: `lpenc_top`

## Requirements
- R1: After reset the count reads 0, the ceiling register reads all ones (0xFFFF at the default width), the compare register reads 0 and the status register reads 0.
- R2: A write to the ceiling register (address 2) or the compare register (address 3) while the enable bit (control bit0) is clear is ignored. The register keeps its old value and its status flag stays clear.
- R3: While enabled, a write to the ceiling register sets status bit0 and a write to the compare register sets status bit1. In both cases the new value and the flag can be read in the cycle after the write.
- R4: Writing a 1 to bit n of the clear register (address 6) clears status bit n. A 0 leaves that bit unchanged.
- R5: Counting starts only when a control write has the start bit (bit1) set while the enable bit is already set. A control write with bit0 clear stops counting, and the count is held.
- R6: With the encoder select clear and the external-source select set, the count increments on each active edge of phase A: rising for code 00, falling for code 01, either for codes 10 and 11. Phase B has no effect in this mode.
- R7: With both the encoder select and the external-source select clear, the count increments on every clock cycle while counting.
- R8: In encoder mode with rising edge selected, a rise of A counts down if B is high and up if B is low. A rise of B counts up if A is high and down if A is low. Falling edges are ignored.
- R9: In encoder mode with falling edge selected, a fall of A counts up if B is high and down if B is low. A fall of B counts down if A is high and up if A is low. Rising edges are ignored.
- R10: In encoder mode with both edges selected, the R8 and R9 rules apply together. One full quadrature cycle therefore moves the count by four.
- R11: Counting up from the ceiling value gives 0. Counting down from 0 gives the ceiling value.
- R12: If A and B both change in the same cycle, the count does not change.
- R13: A change on a phase input shows up on `count_o` two clock edges after it is applied: one edge to register the input, one to update the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| in_a | input | 1 | Phase A, or the count input in counter mode (already synchronised) |
| in_b | input | 1 | Phase B (already synchronised) |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| count_o | output | 16 | Current count |

## Verification
Register writes take effect on the edge that samples the strobe, so the bench reads values and flags back in the following cycle. Phase changes reach `count_o` after exactly two edges. The driver applies each phase pattern at a falling edge, waits two falling edges, and pushes the expected count into a queue. A monitor pops that queue just after the same falling edge and compares. For the free-running clock mode, the bench checks the difference between two samples taken a known number of cycles apart, with wrap included.

// File: rtl/lpenc_pkg.sv
package lpenc_pkg;

  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL   = 3'd0,
    A_CFG    = 3'd1,
    A_RELOAD = 3'd2,
    A_CMP    = 3'd3,
    A_COUNT  = 3'd4,
    A_STATUS = 3'd5,
    A_CLEAR  = 3'd6
  } reg_addr_e;

  typedef enum logic [1:0] {
    EDGE_RISE  = 2'b00,
    EDGE_FALL  = 2'b01,
    EDGE_BOTH  = 2'b10,
    EDGE_BOTH2 = 2'b11
  } edge_sel_e;

  typedef struct packed {
    edge_sel_e edge_sel;
    logic      ext_sel;
    logic      enc_en;
  } cfg_t;

endpackage

// File: rtl/lpenc_regs.sv
module lpenc_regs
  import lpenc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_ni,
  input  logic                  wr_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [CNT_W-1:0]      wdata_i,
  input  logic [CNT_W-1:0]      count_i,
  output logic [CNT_W-1:0]      rdata_o,
  output logic                  enable_o,
  output logic                  running_o,
  output cfg_t                  cfg_o,
  output logic [CNT_W-1:0]      reload_o,
  output logic [1:0]            status_o
);

  localparam int unsigned CFG_W = $bits(cfg_t);

  logic             en_q, en_d;
  logic             run_q, run_d;
  cfg_t             cfg_q, cfg_d;
  logic [CNT_W-1:0] rl_q, rl_d;
  logic [CNT_W-1:0] cmp_q, cmp_d;
  logic [1:0]       st_q, st_d;

  always_comb begin
    en_d  = en_q;
    run_d = run_q;
    cfg_d = cfg_q;
    rl_d  = rl_q;
    cmp_d = cmp_q;
    st_d  = st_q;
    case (addr_i)
      A_CTRL: begin
        en_d  = wdata_i[0];
        run_d = wdata_i[0] & (run_q | (wdata_i[1] & en_q));
      end
      A_CFG: cfg_d = cfg_t'(wdata_i[CFG_W-1:0]);
      A_RELOAD: begin
        if (en_q) begin
          rl_d    = wdata_i;
          st_d[0] = 1'b1;
        end
      end
      A_CMP: begin
        if (en_q) begin
          cmp_d   = wdata_i;
          st_d[1] = 1'b1;
        end
      end
      A_CLEAR: st_d = st_q & ~wdata_i[1:0];
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      run_q <= 1'b0;
      cfg_q <= '0;
      rl_q  <= '1;
      cmp_q <= '0;
      st_q  <= '0;
    end else if (wr_i) begin
      en_q  <= en_d;
      run_q <= run_d;
      cfg_q <= cfg_d;
      rl_q  <= rl_d;
      cmp_q <= cmp_d;
      st_q  <= st_d;
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      A_CTRL:   rdata_o = {{(CNT_W-2){1'b0}}, run_q, en_q};
      A_CFG:    rdata_o = {{(CNT_W-CFG_W){1'b0}}, cfg_q};
      A_RELOAD: rdata_o = rl_q;
      A_CMP:    rdata_o = cmp_q;
      A_COUNT:  rdata_o = count_i;
      A_STATUS: rdata_o = {{(CNT_W-2){1'b0}}, st_q};
      default:  rdata_o = '0;
    endcase
  end

  assign enable_o  = en_q;
  assign running_o = run_q;
  assign cfg_o     = cfg_q;
  assign reload_o  = rl_q;
  assign status_o  = st_q;

endmodule

// File: rtl/lpenc_edge.sv
module lpenc_edge
  import lpenc_pkg::*;
#(
  parameter int unsigned N_PH = 2
) (
  input  logic            clk,
  input  logic            rst_ni,
  input  logic [N_PH-1:0] ph_i,
  input  cfg_t            cfg_i,
  output logic            up_o,
  output logic            dn_o
);

  logic [N_PH-1:0] cur_q, prv_q, rise, fall;

  for (genvar g = 0; g < N_PH; g++) begin : g_ph
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni) begin
        cur_q[g] <= 1'b0;
        prv_q[g] <= 1'b0;
      end else begin
        cur_q[g] <= ph_i[g];
        prv_q[g] <= cur_q[g];
      end
    end
    assign rise[g] = cur_q[g] & ~prv_q[g];
    assign fall[g] = ~cur_q[g] & prv_q[g];
  end

  logic a_lv, b_lv, both_chg, use_r, use_f;
  logic enc_up, enc_dn, ext_up;

  always_comb begin
    a_lv     = cur_q[0];
    b_lv     = cur_q[1];
    both_chg = (rise[0] | fall[0]) & (rise[1] | fall[1]);
    use_r    = (cfg_i.edge_sel == EDGE_RISE) | cfg_i.edge_sel[1];
    use_f    = (cfg_i.edge_sel == EDGE_FALL) | cfg_i.edge_sel[1];
    enc_up   = (use_r & ((rise[0] & ~b_lv) | (rise[1] &  a_lv))) |
               (use_f & ((fall[0] &  b_lv) | (fall[1] & ~a_lv)));
    enc_dn   = (use_r & ((rise[0] &  b_lv) | (rise[1] & ~a_lv))) |
               (use_f & ((fall[0] & ~b_lv) | (fall[1] &  a_lv)));
    ext_up   = (use_r & rise[0]) | (use_f & fall[0]);
    if (cfg_i.enc_en) begin
      up_o = enc_up & ~both_chg;
      dn_o = enc_dn & ~both_chg;
    end else if (cfg_i.ext_sel) begin
      up_o = ext_up & ~both_chg;
      dn_o = 1'b0;
    end else begin
      up_o = 1'b1;
      dn_o = 1'b0;
    end
  end

endmodule

// File: rtl/lpenc_count.sv
module lpenc_count #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             up_i,
  input  logic             dn_i,
  input  logic [CNT_W-1:0] ceil_i,
  output logic [CNT_W-1:0] count_o
);

  localparam logic [CNT_W-1:0] ONE_V = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             step_en;

  always_comb begin
    step_en = run_i & (up_i | dn_i);
    if (up_i) cnt_d = (cnt_q >= ceil_i) ? '0 : cnt_q + ONE_V;
    else      cnt_d = (cnt_q == '0) ? ceil_i : cnt_q - ONE_V;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (step_en) cnt_q <= cnt_d;
  end

  assign count_o = cnt_q;

endmodule

// File: rtl/lpenc_top.sv
module lpenc_top
  import lpenc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_a,
  input  logic              in_b,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [CNT_W-1:0]  count_o
);

  logic       rst_meta, rst_sync;
  logic       enable, running, up, dn;
  cfg_t       cfg;
  logic [CNT_W-1:0] reload;
  logic [1:0] status;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  lpenc_regs #(.CNT_W(CNT_W)) u_regs (
    .clk       (clk),
    .rst_ni    (rst_sync),
    .wr_i      (bus_wr),
    .addr_i    (bus_addr),
    .wdata_i   (bus_wdata),
    .count_i   (count_o),
    .rdata_o   (bus_rdata),
    .enable_o  (enable),
    .running_o (running),
    .cfg_o     (cfg),
    .reload_o  (reload),
    .status_o  (status)
  );

  lpenc_edge #(.N_PH(2)) u_edge (
    .clk    (clk),
    .rst_ni (rst_sync),
    .ph_i   ({in_b, in_a}),
    .cfg_i  (cfg),
    .up_o   (up),
    .dn_o   (dn)
  );

  lpenc_count #(.CNT_W(CNT_W)) u_count (
    .clk     (clk),
    .rst_ni  (rst_sync),
    .run_i   (running),
    .up_i    (up),
    .dn_i    (dn),
    .ceil_i  (reload),
    .count_o (count_o)
  );

endmodule

// File: rtl/lpenc_chk.sv
module lpenc_chk
  import lpenc_pkg::*;
#(
  parameter int unsigned CNT_W = 16
) (
  input logic              clk,
  input logic              rst_ni,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [CNT_W-1:0]  bus_wdata,
  input logic [CNT_W-1:0]  count_o,
  input logic              enable,
  input logic              running,
  input logic [CNT_W-1:0]  reload,
  input logic [1:0]        status,
  input logic              up,
  input logic              dn
);

  logic wr_rl, wr_clr;
  assign wr_rl  = bus_wr && (bus_addr == A_RELOAD);
  assign wr_clr = bus_wr && (bus_addr == A_CLEAR);

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_ni)
    !running |=> $stable(count_o));  // R5
  AST_CEIL_LOCKED: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_rl && !enable) |=> ($stable(reload) && !status[0]) || $past(status[0]));  // R2
  AST_CEIL_FLAG: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_rl && enable) |=> status[0] && (reload == $past(bus_wdata)));  // R3
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_clr && bus_wdata[0]) |=> !status[0]);  // R4
  AST_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_ni)
    (running && up && (count_o == reload) && !wr_rl) |=> (count_o == '0));  // R11
  AST_WRAP_DOWN: assert property (@(posedge clk) disable iff (!rst_ni)
    (running && dn && (count_o == '0) && !wr_rl) |=> (count_o == $past(reload)));  // R11

endmodule

bind lpenc_top lpenc_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_sync),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .count_o   (count_o),
  .enable    (enable),
  .running   (running),
  .reload    (reload),
  .status    (status),
  .up        (up),
  .dn        (dn)
);

// File: tb/lpenc_top_tb_top.sv
module lpenc_top_tb_top;
  import lpenc_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_a, in_b, bus_wr;
  logic [2:0]  bus_addr;
  logic [15:0] bus_wdata, bus_rdata, count_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  lpenc_top dut_i (
    .clk(clk), .rst_n(rst_n), .in_a(in_a), .in_b(in_b),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .count_o(count_o)
  );

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  int    exp_q[$];
  string tag_q[$];

  int       m_cnt = 0, m_ceil = 65535;
  bit       m_run = 0, pa = 0, pb = 0;
  bit [3:0] m_cfg = 4'b0000;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
    @(negedge clk);
    bus_addr = a;
    #1;
    check(int'(bus_rdata) == exp, tag, int'(bus_rdata), exp);
  endtask

  function automatic int delta(input bit a, input bit b);
    bit ar, af, br, bf, use_r, use_f;
    if (!m_run) return 0;
    if (a != pa && b != pb) return 0;
    ar = a & !pa; af = !a & pa; br = b & !pb; bf = !b & pb;
    use_r = (m_cfg[3:2] == 2'b00) || m_cfg[3];
    use_f = (m_cfg[3:2] == 2'b01) || m_cfg[3];
    if (m_cfg[0]) begin
      if (use_r && ar) return b ? -1 : 1;
      if (use_r && br) return a ? 1 : -1;
      if (use_f && af) return b ? 1 : -1;
      if (use_f && bf) return a ? -1 : 1;
      return 0;
    end
    if (m_cfg[1]) return ((use_r && ar) || (use_f && af)) ? 1 : 0;
    return 0;
  endfunction

  task automatic step(input bit a, input bit b, input string tag);
    int d;
    string t;
    t = tag;
    @(negedge clk);
    d = delta(a, b);
    if (d == 1) begin
      if (m_cnt >= m_ceil) begin m_cnt = 0; t = {tag, " R11 up-wrap"}; end
      else m_cnt++;
    end else if (d == -1) begin
      if (m_cnt == 0) begin m_cnt = m_ceil; t = {tag, " R11 down-wrap"}; end
      else m_cnt--;
    end
    in_a = a; in_b = b; pa = a; pb = b;
    repeat (2) @(negedge clk);
    exp_q.push_back(m_cnt);
    tag_q.push_back(t);
  endtask

  // monitor: compares queued expectations just after the falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (exp_q.size() > 0) begin
        int e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(int'(count_o) == e, t, int'(count_o), e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int c0, e;
    rst_n = 1'b0; in_a = 0; in_b = 0; bus_wr = 0; bus_addr = '0; bus_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    check(count_o == 0, "R1 count after reset", int'(count_o), 0);
    rd_chk(A_RELOAD, 65535, "R1 ceiling after reset");
    rd_chk(A_CMP, 0, "R1 compare after reset");
    rd_chk(A_STATUS, 0, "R1 status after reset");

    wr(A_RELOAD, 16'd7);
    rd_chk(A_RELOAD, 65535, "R2 ceiling write while disabled");
    rd_chk(A_STATUS, 0, "R2 no flag while disabled");
    wr(A_CMP, 16'd9);
    rd_chk(A_CMP, 0, "R2 compare write while disabled");

    m_cfg = 4'b0010; wr(A_CFG, 16'h0002);
    wr(A_CTRL, 16'h0003);
    step(1, 0, "R5 start ignored from disabled");
    step(0, 0, "R5 start ignored from disabled");

    wr(A_RELOAD, 16'd5); m_ceil = 5;
    rd_chk(A_STATUS, 1, "R3 ceiling flag");
    wr(A_CMP, 16'd2);
    rd_chk(A_STATUS, 3, "R3 compare flag");
    rd_chk(A_CMP, 2, "R3 compare value");
    rd_chk(A_RELOAD, 5, "R3 ceiling value");
    wr(A_CLEAR, 16'h0001);
    rd_chk(A_STATUS, 2, "R4 clear bit0 only");
    wr(A_CLEAR, 16'h0002);
    rd_chk(A_STATUS, 0, "R4 clear bit1");

    wr(A_CTRL, 16'h0003); m_run = 1;

    // R13 latency on a rising edge of A
    @(negedge clk); in_a = 1; pa = 1;
    @(negedge clk); #1;
    check(count_o == 0, "R13 one edge after input", int'(count_o), 0);
    @(negedge clk); #1;
    check(count_o == 1, "R13 two edges after input", int'(count_o), 1);
    m_cnt = 1;

    step(0, 0, "R6 rising fall ignored");
    step(0, 1, "R6 B ignored");
    step(0, 0, "R6 B ignored");
    step(1, 0, "R6 rising count");
    step(1, 1, "R6 B ignored");
    step(0, 1, "R6 rising fall ignored");
    step(1, 0, "R12 both change");
    for (int i = 0; i < 4; i++) begin
      step(0, 0, "R6 rising");
      step(1, 0, "R6 rising");
    end

    m_cfg = 4'b0110; wr(A_CFG, 16'h0006);
    step(0, 0, "R6 falling count");
    step(1, 0, "R6 falling rise ignored");
    step(0, 0, "R6 falling count");
    m_cfg = 4'b1010; wr(A_CFG, 16'h000A);
    step(1, 0, "R6 both edges");
    step(0, 0, "R6 both edges");

    // R7 internal clock counting
    wr(A_CFG, 16'h0000);
    @(negedge clk); c0 = int'(count_o);
    repeat (3) @(negedge clk);
    e = c0;
    for (int i = 0; i < 3; i++) e = (e >= 5) ? 0 : e + 1;
    check(int'(count_o) == e, "R7 counts every cycle", int'(count_o), e);
    wr(A_CTRL, 16'h0000); m_run = 0;
    @(negedge clk); m_cnt = int'(count_o);
    repeat (3) @(negedge clk);
    check(int'(count_o) == m_cnt, "R5 held after disable", int'(count_o), m_cnt);
    m_cfg = 4'b0010; wr(A_CFG, 16'h0002);
    step(1, 0, "R5 edges ignored while stopped");
    step(0, 0, "R5 edges ignored while stopped");
    wr(A_CTRL, 16'h0001); wr(A_CTRL, 16'h0003); m_run = 1;

    m_cfg = 4'b0001; wr(A_CFG, 16'h0001);
    step(1, 0, "R8 A rise B low up");
    step(1, 1, "R8 B rise A high up");
    step(0, 1, "R8 fall ignored");
    step(0, 0, "R8 fall ignored");
    step(0, 1, "R8 B rise A low down");
    step(1, 1, "R8 A rise B high down");
    step(0, 1, "R8 fall ignored");
    step(0, 0, "R8 fall ignored");

    m_cfg = 4'b0101; wr(A_CFG, 16'h0005);
    step(1, 0, "R9 rise ignored");
    step(1, 1, "R9 rise ignored");
    step(0, 1, "R9 A fall B high up");
    step(0, 0, "R9 B fall A low up");
    step(0, 1, "R9 rise ignored");
    step(1, 1, "R9 rise ignored");
    step(1, 0, "R9 B fall A high down");
    step(0, 0, "R9 A fall B low down");

    m_cfg = 4'b1001; wr(A_CFG, 16'h0009);
    step(1, 0, "R10 forward");
    step(1, 1, "R10 forward");
    step(0, 1, "R10 forward");
    step(0, 0, "R10 forward");
    for (int i = 0; i < 2; i++) begin
      step(0, 1, "R10 reverse");
      step(1, 1, "R10 reverse");
      step(1, 0, "R10 reverse");
      step(0, 0, "R10 reverse");
    end
    step(1, 1, "R12 simultaneous change");
    step(0, 0, "R12 simultaneous change");

    repeat (4) @(negedge clk);
    finish_run();
  end

endmodule